// File: doc/BRIEF.md
# Operand Bypass Select and Load Hazard Stall

This is a purely combinational control block for a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. For each of the two ALU operands of the instruction now in execute, it chooses where the value comes from. The choices are the result waiting in the execute/memory pipeline register, the result waiting in the memory/writeback register, or the value read from the register file. When both later stages hold a matching result, the younger one, in execute/memory, is taken.

The block also catches the one dependence that bypassing cannot cover. That case is a load in execute whose destination is read by the instruction in decode. For that cycle it asks the surrounding pipeline to freeze the program counter and the fetch/decode register, and to load an empty (all control fields zero) slot into the decode/execute register. One cycle later the loaded word sits in the memory/writeback register and the normal bypass path delivers it.

The datapath multiplexers, the ALU and the register file are outside this block. Destination numbers arrive already chosen by the decoder: bits 15:11 of the instruction for register-register operations, and bits 20:16 for loads and immediate forms. They are then carried down the pipeline registers.

Top module: `fwd_hazard_unit`

## Requirements
- R1: If the execute/memory stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10. Each operand is checked on its own, so a store base operand or either source of a two-source instruction can take it.
- R2: If only the memory/writeback stage writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01.
- R3: If both stages match the same source, the select is 2'b10, so the newest result wins.
- R4: Register number 0 is never bypassed. A source of 0 always gives select 2'b00.
- R5: A stage whose write enable is low is never bypassed, even when its destination number matches.
- R6: With no qualifying match, the select is 2'b00, which means the register file.
- R7: When the decode/execute register holds a load with a nonzero destination equal to either decode-stage source, both `hold_front` and `insert_bubble` are 1.
- R8: The stall outputs are 0 in the following cases: the instruction is not a load, the load destination is 0, or the load destination matches neither decode source. `hold_front` always equals `insert_bubble`.
- R9: An operand select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_a | input | RW | First source register of the instruction in execute |
| ex_rs_b | input | RW | Second source register of the instruction in execute |
| xm_rd | input | RW | Destination held in the execute/memory register |
| xm_we | input | 1 | Register write enable held in the execute/memory register |
| mw_rd | input | RW | Destination held in the memory/writeback register |
| mw_we | input | 1 | Register write enable held in the memory/writeback register |
| id_rs_a | input | RW | First source register of the instruction in decode |
| id_rs_b | input | RW | Second source register of the instruction in decode |
| dx_load | input | 1 | Decode/execute register holds a load |
| dx_rd | input | RW | Destination held in the decode/execute register |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| insert_bubble | output | 1 | Zero the control fields loaded into decode/execute |

## Verification
The bench goes after the priority case, where both later stages name the same register. A design with the order reversed would feed the older memory/writeback value and compute with stale data. It drives matches on register 0 and matches from stages whose write enable is low. A unit that ignored either condition would bypass garbage in place of the correct register-file value. For the stall, it checks a load hitting each decode source separately, and it also checks non-load and zero-destination near misses. A wrong unit would miss the single stall that is needed, or would throw away cycles on dependences that bypassing already covers.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_rs_a,
  input  logic [RW-1:0] ex_rs_b,
  input  logic [RW-1:0] xm_rd,
  input  logic          xm_we,
  input  logic [RW-1:0] mw_rd,
  input  logic          mw_we,
  input  logic [RW-1:0] id_rs_a,
  input  logic [RW-1:0] id_rs_b,
  input  logic          dx_load,
  input  logic [RW-1:0] dx_rd,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          hold_front,
  output logic          insert_bubble
);
  localparam logic [RW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SRC_RF = 2'b00;
  localparam logic [1:0] SRC_XM = 2'b10;
  localparam logic [1:0] SRC_MW = 2'b01;

  logic xm_live, mw_live;
  assign xm_live = xm_we && (xm_rd != ZERO_REG);
  assign mw_live = mw_we && (mw_rd != ZERO_REG);

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (xm_live && xm_rd == src)      pick = SRC_XM;
    else if (mw_live && mw_rd == src) pick = SRC_MW;
    else                              pick = SRC_RF;
  endfunction

  assign sel_a = pick(ex_rs_a);
  assign sel_b = pick(ex_rs_b);

  logic load_hit;
  assign load_hit = dx_load && (dx_rd != ZERO_REG) &&
                    ((dx_rd == id_rs_a) || (dx_rd == id_rs_b));

  assign hold_front    = load_hit;
  assign insert_bubble = load_hit;
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] ex_rs_a,
  input logic [RW-1:0] ex_rs_b,
  input logic [RW-1:0] xm_rd,
  input logic          xm_we,
  input logic [RW-1:0] mw_rd,
  input logic          mw_we,
  input logic [RW-1:0] id_rs_a,
  input logic [RW-1:0] id_rs_b,
  input logic          dx_load,
  input logic [RW-1:0] dx_rd,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          hold_front,
  input logic          insert_bubble
);
  always_comb begin
    AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R9
    AST_ZERO_SRC_A: assert (ex_rs_a != '0 || sel_a == 2'b00); // R4
    AST_ZERO_SRC_B: assert (ex_rs_b != '0 || sel_b == 2'b00); // R4
    AST_XM_NEEDS_WE: assert (sel_a != 2'b10 || (xm_we && xm_rd == ex_rs_a)); // R5
    AST_MW_NEEDS_WE: assert (sel_b != 2'b01 || (mw_we && mw_rd == ex_rs_b)); // R5
    AST_NEWEST_WINS: assert (!(xm_we && xm_rd == ex_rs_a && ex_rs_a != '0) || sel_a == 2'b10); // R3
    AST_STALL_PAIR: assert (hold_front == insert_bubble); // R8
    AST_STALL_ONLY_LOAD: assert (dx_load || !hold_front); // R8
    AST_STALL_ON_HIT: assert (!(dx_load && dx_rd != '0 && dx_rd == id_rs_a) || hold_front); // R7
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.RW(RW)) u_chk (.*);

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
  localparam int RW = 5;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [RW-1:0] ex_rs_a, ex_rs_b, xm_rd, mw_rd, id_rs_a, id_rs_b, dx_rd;
  logic xm_we, mw_we, dx_load;
  logic [1:0] sel_a, sel_b;
  logic hold_front, insert_bubble;

  int n_chk = 0, n_bad = 0;

  fwd_hazard_unit #(.RW(RW)) u_dut (.*);

  task automatic clear();
    ex_rs_a = 0; ex_rs_b = 0; xm_rd = 0; mw_rd = 0; id_rs_a = 0; id_rs_b = 0;
    dx_rd = 0; xm_we = 0; mw_we = 0; dx_load = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    clear(); settle();
    chk("R6 idle selects", {sel_a, sel_b}, 4'b0000);
    chk("R8 idle stall", {2'b00, hold_front, insert_bubble}, 4'b0000);
  endtask

  task automatic t_xm_fwd();
    clear(); ex_rs_a = 7; ex_rs_b = 9; xm_rd = 7; xm_we = 1; settle();
    chk("R1 xm on a", {sel_a, sel_b}, 4'b1000);
    ex_rs_a = 3; xm_rd = 9; settle();
    chk("R1 xm on b", {sel_a, sel_b}, 4'b0010);
    ex_rs_a = 9; settle();
    chk("R1 xm on both", {sel_a, sel_b}, 4'b1010);
  endtask

  task automatic t_mw_fwd();
    clear(); ex_rs_a = 12; ex_rs_b = 5; mw_rd = 5; mw_we = 1; settle();
    chk("R2 mw on b", {sel_a, sel_b}, 4'b0001);
    ex_rs_a = 5; settle();
    chk("R2 mw on both", {sel_a, sel_b}, 4'b0101);
  endtask

  task automatic t_priority();
    clear(); ex_rs_a = 4; ex_rs_b = 4; xm_rd = 4; mw_rd = 4; xm_we = 1; mw_we = 1; settle();
    chk("R3 newest wins", {sel_a, sel_b}, 4'b1010);
    ex_rs_b = 6; mw_rd = 6; settle();
    chk("R3 split sources", {sel_a, sel_b}, 4'b1001);
  endtask

  task automatic t_zero_reg();
    clear(); xm_we = 1; mw_we = 1; settle();
    chk("R4 r0 never forwards", {sel_a, sel_b}, 4'b0000);
  endtask

  task automatic t_we_low();
    clear(); ex_rs_a = 8; ex_rs_b = 8; xm_rd = 8; mw_rd = 8; settle();
    chk("R5 both we low", {sel_a, sel_b}, 4'b0000);
    mw_we = 1; settle();
    chk("R5 xm we low falls to mw", {sel_a, sel_b}, 4'b0101);
  endtask

  task automatic t_no_match();
    clear(); ex_rs_a = 1; ex_rs_b = 2; xm_rd = 3; mw_rd = 4; xm_we = 1; mw_we = 1; settle();
    chk("R6 no match", {sel_a, sel_b}, 4'b0000);
  endtask

  task automatic t_load_use();
    clear(); dx_load = 1; dx_rd = 10; id_rs_a = 10; id_rs_b = 2; settle();
    chk("R7 load hit a", {2'b00, hold_front, insert_bubble}, 4'b0011);
    id_rs_a = 1; id_rs_b = 10; settle();
    chk("R7 load hit b", {2'b00, hold_front, insert_bubble}, 4'b0011);
  endtask

  task automatic t_no_stall();
    clear(); dx_rd = 10; id_rs_a = 10; settle();
    chk("R8 non-load no stall", {2'b00, hold_front, insert_bubble}, 4'b0000);
    dx_load = 1; dx_rd = 0; id_rs_a = 0; settle();
    chk("R8 load to r0 no stall", {2'b00, hold_front, insert_bubble}, 4'b0000);
    dx_rd = 11; id_rs_a = 12; id_rs_b = 13; settle();
    chk("R8 load miss no stall", {2'b00, hold_front, insert_bubble}, 4'b0000);
  endtask

  task automatic t_sel_legal();
    for (int k = 0; k < 32; k++) begin
      clear(); ex_rs_a = k[4:0]; ex_rs_b = 5'(31 - k); xm_rd = 5'(k % 4); mw_rd = 5'(k % 3);
      xm_we = k[0]; mw_we = k[1]; settle();
      chk("R9 select legal", {2'b00, sel_a == 2'b11, sel_b == 2'b11}, 4'b0000);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_xm_fwd();
    t_mw_fwd();
    t_priority();
    t_zero_reg();
    t_we_low();
    t_no_match();
    t_load_use();
    t_no_stall();
    t_sel_legal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule